// File: doc/BRIEF.md
# Variable-Length Vector Lane Sequencer

This block is the execute-stage sequencer of a four-lane vector coprocessor. A run-time length register sets how many 32-bit elements each vector instruction covers. The length is always a multiple of the lane count, up to 32. When the dispatcher hands over a decoded operation, the sequencer steps through the vector one 4-element chunk per cycle. On each step it reads two source rows and the old destination row from a banked register file of 4-element rows, passes the operands through a lane ALU stub, merges the result under a per-element mask and writes the row back. Each row write is also presented on the writeback port.

The sequencer has three states. `ST_IDLE` is ready and waiting. `ST_BUSY` means chunks remain after the current one. `ST_LAST` is the final chunk and asserts `done`. The transitions are:
- issue accepted with one chunk: `ST_IDLE`→`ST_LAST`
- issue accepted with more than one chunk: `ST_IDLE`→`ST_BUSY`
- counter reaching the next-to-last chunk: `ST_BUSY`→`ST_BUSY`, then `ST_BUSY`→`ST_LAST`
- final chunk written: `ST_LAST`→`ST_IDLE`

Top module: `vlen_lane_seq`

## Requirements
- R1: After reset `issue_ready` is 1, `wb_valid` and `done` are 0, and `cur_len` reads 32.
- R2: A control write with a value that is nonzero, a multiple of 4 and at most 32 sets `cur_len` from the next cycle on. A write of 0, of a value that is not a multiple of 4, or of a value above 32 leaves `cur_len` unchanged.
- R3: An instruction uses the length held when it is accepted. A control write in the same cycle as an accepted issue affects only later instructions.
- R4: An instruction accepted with length L produces exactly L/4 writebacks on consecutive cycles. The first comes in the cycle after acceptance. `done` is 1 together with the last writeback only.
- R5: `issue_ready` is 0 from the cycle after acceptance for exactly L/4 cycles. An `issue_valid` presented while `issue_ready` is 0 produces no writeback.
- R6: Vector register v, chunk c, uses register-file row (v*(L/4)+c) mod 32. For the destination, this row number appears on `wb_entry`.
- R7: `issue_op` encoding, with wrapping 32-bit arithmetic:
  - 0: vs1+vs2
  - 1: vs1−vs2
  - 2: vs1 XOR vs2
  - 3: `issue_scalar` plus the element index
- R8: Lane l of a row occupies `wb_data` bits [32l+31:32l] and holds element index 4c+l. Bit e of `issue_mask`, captured at acceptance, enables element e. For a masked-off element, `wb_lane_we` bit l is 0, `wb_data` shows the old destination value, and the stored value is kept.
- R9: Source reads see every row written before them, including rows written by earlier chunks of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Vector-length control write strobe |
| ctl_wr_len | input | 6 | Requested vector length |
| cur_len | output | 6 | Current vector length |
| issue_valid | input | 1 | Decoded vector operation offered |
| issue_ready | output | 1 | Sequencer idle, operation accepted this cycle if offered |
| issue_op | input | 2 | Operation code |
| issue_vd | input | 5 | Destination vector register |
| issue_vs1 | input | 5 | First source vector register |
| issue_vs2 | input | 5 | Second source vector register |
| issue_mask | input | 32 | Per-element enable mask |
| issue_scalar | input | 32 | Scalar operand for fill |
| wb_valid | output | 1 | A row is written this cycle |
| wb_entry | output | 5 | Register-file row being written |
| wb_lane_we | output | 4 | Per-lane write enable |
| wb_data | output | 128 | Merged row value |
| done | output | 1 | Last chunk of the instruction |

## Verification
A length write shows on `cur_len` in the cycle after its strobe. Chunk c of an instruction accepted at edge k appears on the writeback port between edges k+c and k+c+1. `issue_ready` returns after L/4 such cycles. The driver changes inputs on falling edges, and every observation is taken shortly after a falling edge. Each check therefore sees the settled values of the cycle it targets. The driver queues one expected row per chunk from its own register-file and length model, and the monitor pops one item per cycle in which `wb_valid` is high. Any writeback with an empty queue counts as a failure, which exposes a wrong chunk count or an instruction accepted while busy.

// File: rtl/vlen_seq_pkg.sv
`timescale 1ns/1ps
package vlen_seq_pkg;

    localparam int unsigned LANES_D    = 4;
    localparam int unsigned ELEM_W_D   = 32;
    localparam int unsigned MAX_LEN_D  = 32;
    localparam int unsigned RF_DEPTH_D = 32;
    localparam int unsigned REG_W_D    = 5;

    typedef enum logic [1:0] {
        VOP_ADD  = 2'd0,
        VOP_SUB  = 2'd1,
        VOP_XOR  = 2'd2,
        VOP_FILL = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_LAST = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vlen_ctrl.sv
`timescale 1ns/1ps
module vlen_ctrl #(
    parameter  int unsigned LANES     = vlen_seq_pkg::LANES_D,
    parameter  int unsigned MAX_LEN   = vlen_seq_pkg::MAX_LEN_D,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned LANE_BITS = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] len_q
);

    logic legal;

    // A length is usable only if it fills whole lane groups and fits the rows.
    always_comb begin
        legal = (wr_len != '0)
             && (wr_len[LANE_BITS-1:0] == '0)
             && (wr_len <= LEN_W'(MAX_LEN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_W'(MAX_LEN);
        end else if (wr_en && legal) begin
            len_q <= wr_len;
        end
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) && (len_q[LANE_BITS-1:0] == '0) && (len_q <= LEN_W'(MAX_LEN))) // R2
        else $error("length register holds an illegal value");

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(len_q)) // R2
        else $error("length changed without a control write");

endmodule

// File: rtl/vseq_fsm.sv
`timescale 1ns/1ps
module vseq_fsm
    import vlen_seq_pkg::*;
#(
    parameter  int unsigned LANES     = LANES_D,
    parameter  int unsigned MAX_LEN   = MAX_LEN_D,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned LANE_BITS = $clog2(LANES),
    localparam int unsigned CNT_W     = $clog2(MAX_LEN / LANES + 1),
    localparam int unsigned CHUNK_W   = $clog2(MAX_LEN / LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [LEN_W-1:0]   len_in,
    output logic               accept,
    output logic               issue_ready,
    output logic               wb_valid,
    output logic               done,
    output logic [CHUNK_W-1:0] chunk,
    output logic [CNT_W-1:0]   chunks
);

    seq_state_e          state_q, state_d;
    logic [CHUNK_W-1:0]  chunk_q, chunk_d;
    logic [CNT_W-1:0]    chunks_q, chunks_d;
    logic [CNT_W-1:0]    chunks_in;

    assign chunks_in = CNT_W'(len_in >> LANE_BITS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            chunk_q  <= '0;
            chunks_q <= '0;
        end else begin
            state_q  <= state_d;
            chunk_q  <= chunk_d;
            chunks_q <= chunks_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        chunk_d  = chunk_q;
        chunks_d = chunks_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    chunks_d = chunks_in;
                    chunk_d  = '0;
                    state_d  = (chunks_in == CNT_W'(1)) ? ST_LAST : ST_BUSY;
                end
            end
            ST_BUSY: begin
                chunk_d = chunk_q + CHUNK_W'(1);
                if (CNT_W'(chunk_q) + CNT_W'(2) == chunks_q) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        issue_ready = 1'b0;
        wb_valid    = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: issue_ready = 1'b1;
            ST_BUSY: wb_valid    = 1'b1;
            ST_LAST: begin
                wb_valid = 1'b1;
                done     = 1'b1;
            end
            default: issue_ready = 1'b0;
        endcase
    end

    assign accept = issue_valid && issue_ready;
    assign chunk  = chunk_q;
    assign chunks = chunks_q;

    AST_READY_FALL_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(issue_ready) |-> $past(issue_valid)) // R5
        else $error("ready dropped without an accepted issue");

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> issue_ready) // R5
        else $error("ready not restored after the last chunk");

    AST_CHUNK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (CNT_W'(chunk_q) < chunks_q)) // R4
        else $error("chunk counter beyond instruction length");

    AST_LAST_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (CNT_W'(chunk_q) + CNT_W'(1) == chunks_q)) // R4
        else $error("done raised before the final chunk");

endmodule

// File: rtl/vrf_bank.sv
`timescale 1ns/1ps
module vrf_bank #(
    parameter  int unsigned LANES  = vlen_seq_pkg::LANES_D,
    parameter  int unsigned ELEM_W = vlen_seq_pkg::ELEM_W_D,
    parameter  int unsigned DEPTH  = vlen_seq_pkg::RF_DEPTH_D,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ROW_W  = LANES * ELEM_W
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [ROW_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [ROW_W-1:0] rd_b_data,
    input  logic [IDX_W-1:0] rd_c_idx,
    output logic [ROW_W-1:0] rd_c_data,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_lane_en,
    input  logic [ROW_W-1:0] wr_data
);

    // One storage bank per lane, each with its own write enable.
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [ELEM_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane_en[l]) begin
                mem[wr_idx] <= wr_data[l*ELEM_W +: ELEM_W];
            end
        end

        assign rd_a_data[l*ELEM_W +: ELEM_W] = mem[rd_a_idx];
        assign rd_b_data[l*ELEM_W +: ELEM_W] = mem[rd_b_idx];
        assign rd_c_data[l*ELEM_W +: ELEM_W] = mem[rd_c_idx];
    end

endmodule

// File: rtl/vlane_alu.sv
`timescale 1ns/1ps
module vlane_alu
    import vlen_seq_pkg::*;
#(
    parameter int unsigned ELEM_W = ELEM_W_D,
    parameter int unsigned EIDX_W = 5
) (
    input  vop_e              op,
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    input  logic [ELEM_W-1:0] scalar,
    input  logic [EIDX_W-1:0] eidx,
    output logic [ELEM_W-1:0] y
);

    always_comb begin
        unique case (op)
            VOP_ADD:  y = a + b;
            VOP_SUB:  y = a - b;
            VOP_XOR:  y = a ^ b;
            VOP_FILL: y = scalar + ELEM_W'(eidx);
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/vlen_lane_seq.sv
`timescale 1ns/1ps
module vlen_lane_seq
    import vlen_seq_pkg::*;
#(
    parameter  int unsigned LANES     = LANES_D,
    parameter  int unsigned ELEM_W    = ELEM_W_D,
    parameter  int unsigned MAX_LEN   = MAX_LEN_D,
    parameter  int unsigned RF_DEPTH  = RF_DEPTH_D,
    parameter  int unsigned REG_W     = REG_W_D,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned LANE_BITS = $clog2(LANES),
    localparam int unsigned CNT_W     = $clog2(MAX_LEN / LANES + 1),
    localparam int unsigned CHUNK_W   = $clog2(MAX_LEN / LANES),
    localparam int unsigned EIDX_W    = $clog2(MAX_LEN),
    localparam int unsigned IDX_W     = $clog2(RF_DEPTH),
    localparam int unsigned ROW_W     = LANES * ELEM_W,
    localparam int unsigned PROD_W    = REG_W + CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr_en,
    input  logic [LEN_W-1:0]   ctl_wr_len,
    output logic [LEN_W-1:0]   cur_len,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [1:0]         issue_op,
    input  logic [REG_W-1:0]   issue_vd,
    input  logic [REG_W-1:0]   issue_vs1,
    input  logic [REG_W-1:0]   issue_vs2,
    input  logic [MAX_LEN-1:0] issue_mask,
    input  logic [ELEM_W-1:0]  issue_scalar,
    output logic               wb_valid,
    output logic [IDX_W-1:0]   wb_entry,
    output logic [LANES-1:0]   wb_lane_we,
    output logic [ROW_W-1:0]   wb_data,
    output logic               done
);

    logic [LEN_W-1:0]   len_q;
    logic               accept;
    logic               rdy;
    logic               seq_valid;
    logic               seq_done;
    logic [CHUNK_W-1:0] chunk;
    logic [CNT_W-1:0]   chunks;

    vop_e               op_q;
    logic [REG_W-1:0]   vd_q, vs1_q, vs2_q;
    logic [MAX_LEN-1:0] mask_q;
    logic [ELEM_W-1:0]  scalar_q;

    logic [IDX_W-1:0]   ent_vd, ent_vs1, ent_vs2;
    logic [ROW_W-1:0]   row_a, row_b, row_old;
    logic [ROW_W-1:0]   row_new;
    logic [LANES-1:0]   lane_we;

    vlen_ctrl #(.LANES(LANES), .MAX_LEN(MAX_LEN)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr_en),
        .wr_len (ctl_wr_len),
        .len_q  (len_q)
    );

    vseq_fsm #(.LANES(LANES), .MAX_LEN(MAX_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .len_in      (len_q),
        .accept      (accept),
        .issue_ready (rdy),
        .wb_valid    (seq_valid),
        .done        (seq_done),
        .chunk       (chunk),
        .chunks      (chunks)
    );

    // Instruction fields held for the whole sweep.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= VOP_ADD;
            vd_q     <= '0;
            vs1_q    <= '0;
            vs2_q    <= '0;
            mask_q   <= '0;
            scalar_q <= '0;
        end else if (accept) begin
            op_q     <= vop_e'(issue_op);
            vd_q     <= issue_vd;
            vs1_q    <= issue_vs1;
            vs2_q    <= issue_vs2;
            mask_q   <= issue_mask;
            scalar_q <= issue_scalar;
        end
    end

    // Row of register v for the current chunk: v * chunks + chunk, wrapped.
    assign ent_vd  = IDX_W'(PROD_W'(vd_q)  * PROD_W'(chunks)) + IDX_W'(chunk);
    assign ent_vs1 = IDX_W'(PROD_W'(vs1_q) * PROD_W'(chunks)) + IDX_W'(chunk);
    assign ent_vs2 = IDX_W'(PROD_W'(vs2_q) * PROD_W'(chunks)) + IDX_W'(chunk);

    vrf_bank #(.LANES(LANES), .ELEM_W(ELEM_W), .DEPTH(RF_DEPTH)) u_rf (
        .clk        (clk),
        .rd_a_idx   (ent_vs1),
        .rd_a_data  (row_a),
        .rd_b_idx   (ent_vs2),
        .rd_b_data  (row_b),
        .rd_c_idx   (ent_vd),
        .rd_c_data  (row_old),
        .wr_idx     (ent_vd),
        .wr_lane_en (lane_we),
        .wr_data    (row_new)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EIDX_W-1:0] eidx;
        logic [ELEM_W-1:0] res;
        logic              lane_on;

        assign eidx = {chunk, LANE_BITS'(l)};

        vlane_alu #(.ELEM_W(ELEM_W), .EIDX_W(EIDX_W)) u_alu (
            .op     (op_q),
            .a      (row_a[l*ELEM_W +: ELEM_W]),
            .b      (row_b[l*ELEM_W +: ELEM_W]),
            .scalar (scalar_q),
            .eidx   (eidx),
            .y      (res)
        );

        assign lane_on = seq_valid && mask_q[eidx];
        assign lane_we[l] = lane_on;
        assign row_new[l*ELEM_W +: ELEM_W] =
            lane_on ? res : row_old[l*ELEM_W +: ELEM_W];
    end

    assign cur_len     = len_q;
    assign issue_ready = rdy;
    assign wb_valid    = seq_valid;
    assign wb_entry    = ent_vd;
    assign wb_lane_we  = lane_we;
    assign wb_data     = row_new;
    assign done        = seq_done;

    AST_DONE_HAS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wb_valid) // R4
        else $error("done without a writeback");

    AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid) && !$past(done)) |->
            (wb_entry == $past(wb_entry) + IDX_W'(1))) // R6
        else $error("destination row did not advance by one");

    AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> (wb_lane_we == '0)) // R5
        else $error("row write while idle");

endmodule

// File: tb/vlen_lane_seq_tb.sv
`timescale 1ns/1ps
module vlen_lane_seq_tb;
    import vlen_seq_pkg::*;

    typedef struct {
        logic [4:0]   entry;
        logic [127:0] data;
        logic [3:0]   we;
        logic         last;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_wr_en = 1'b0;
    logic [5:0]   ctl_wr_len = '0;
    logic [5:0]   cur_len;
    logic         issue_valid = 1'b0;
    logic         issue_ready;
    logic [1:0]   issue_op = '0;
    logic [4:0]   issue_vd = '0, issue_vs1 = '0, issue_vs2 = '0;
    logic [31:0]  issue_mask = '0;
    logic [31:0]  issue_scalar = '0;
    logic         wb_valid;
    logic [4:0]   wb_entry;
    logic [3:0]   wb_lane_we;
    logic [127:0] wb_data;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    exp_t        q[$];
    logic [31:0] m_rf [32][4];
    int          m_len = 32;

    always #4 clk = ~clk;

    vlen_lane_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_len   (ctl_wr_len),
        .cur_len      (cur_len),
        .issue_valid  (issue_valid),
        .issue_ready  (issue_ready),
        .issue_op     (issue_op),
        .issue_vd     (issue_vd),
        .issue_vs1    (issue_vs1),
        .issue_vs2    (issue_vs2),
        .issue_mask   (issue_mask),
        .issue_scalar (issue_scalar),
        .wb_valid     (wb_valid),
        .wb_entry     (wb_entry),
        .wb_lane_we   (wb_lane_we),
        .wb_data      (wb_data),
        .done         (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic bit len_ok(input int v);
        return (v != 0) && (v % 4 == 0) && (v <= 32);
    endfunction

    // Monitor: one expected row per writeback cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && wb_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R5", "unexpected writeback", {123'b0, wb_entry}, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(wb_entry == e.entry, "R6", "row index", {123'b0, wb_entry}, {123'b0, e.entry});
                    chk(wb_data == e.data, "R8", "row data", wb_data, e.data);
                    chk(wb_lane_we == e.we, "R8", "lane enables", {124'b0, wb_lane_we}, {124'b0, e.we});
                    chk(done == e.last, "R4", "done flag", {127'b0, done}, {127'b0, e.last});
                end
            end else if (rst_n && done) begin
                chk(0, "R4", "done without writeback", 128'd1, 128'd0);
            end
        end
    end

    task automatic set_len(input int v);
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        ctl_wr_en  = 1'b1;
        ctl_wr_len = 6'(v);
        @(negedge clk);
        ctl_wr_en = 1'b0;
        if (len_ok(v)) m_len = v;
        chk(cur_len == 6'(m_len), "R2", $sformatf("length after write of %0d", v),
            {122'b0, cur_len}, 128'(m_len));
    endtask

    // Driver: queues the expected rows, offers the operation, then counts busy cycles.
    task automatic issue(input vop_e op, input int vd, input int vs1, input int vs2,
                         input logic [31:0] mask, input logic [31:0] scal,
                         input bit with_ctl, input int ctl_len, input bit probe);
        int chunks;
        int n;
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        chunks = m_len / 4;
        for (int c = 0; c < chunks; c++) begin
            int ed, e1, e2;
            logic [127:0] d;
            logic [3:0] w;
            exp_t item;
            ed = (vd * chunks + c) % 32;
            e1 = (vs1 * chunks + c) % 32;
            e2 = (vs2 * chunks + c) % 32;
            d = '0;
            w = '0;
            for (int l = 0; l < 4; l++) begin
                logic [31:0] a, b, r;
                int e;
                e = c * 4 + l;
                a = m_rf[e1][l];
                b = m_rf[e2][l];
                case (op)
                    VOP_ADD: r = a + b;
                    VOP_SUB: r = a - b;
                    VOP_XOR: r = a ^ b;
                    default: r = scal + 32'(e);
                endcase
                if (mask[e]) begin
                    d[l*32 +: 32] = r;
                    w[l] = 1'b1;
                end else begin
                    d[l*32 +: 32] = m_rf[ed][l];
                end
            end
            for (int l = 0; l < 4; l++) begin
                if (w[l]) m_rf[ed][l] = d[l*32 +: 32];
            end
            item.entry = 5'(ed);
            item.data  = d;
            item.we    = w;
            item.last  = (c == chunks - 1);
            q.push_back(item);
        end
        issue_op     = 2'(op);
        issue_vd     = 5'(vd);
        issue_vs1    = 5'(vs1);
        issue_vs2    = 5'(vs2);
        issue_mask   = mask;
        issue_scalar = scal;
        issue_valid  = 1'b1;
        if (with_ctl) begin
            ctl_wr_en  = 1'b1;
            ctl_wr_len = 6'(ctl_len);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        ctl_wr_en   = 1'b0;
        if (with_ctl && len_ok(ctl_len)) m_len = ctl_len;
        n = 0;
        while (!issue_ready) begin
            n++;
            if (probe) begin
                // R5: offered while busy, must never be taken
                issue_valid  = 1'b1;
                issue_op     = 2'(VOP_FILL);
                issue_vd     = 5'd0;
                issue_mask   = '1;
                issue_scalar = 32'hDEAD_0000;
            end
            @(negedge clk);
        end
        issue_valid = 1'b0;
        chk(n == chunks, "R5", "ready-low cycles", 128'(n), 128'(chunks));
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "WATCHDOG", "run did not finish", '0, '0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(issue_ready == 1'b1, "R1", "ready after reset", {127'b0, issue_ready}, 128'd1);
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", {127'b0, wb_valid}, 128'd0);
        chk(done == 1'b0, "R1", "done after reset", {127'b0, done}, 128'd0);
        chk(cur_len == 6'd32, "R1", "length after reset", {122'b0, cur_len}, 128'd32);

        // R7 fill, R6 mapping at full length: registers 0..3 cover all 32 rows
        for (int v = 0; v < 4; v++) begin
            issue(VOP_FILL, v, 0, 0, 32'hFFFF_FFFF, 32'h1000 * (v + 1), 0, 0, 0);
        end
        issue(VOP_ADD, 3, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);            // R7 add
        issue(VOP_SUB, 2, 3, 0, 32'h0F0F_F0F0, 0, 0, 0, 0);            // R7 sub, R8 mask
        issue(VOP_XOR, 5, 1, 2, 32'h8000_0001, 0, 0, 0, 0);            // R6 wrap, R8

        // R2 illegal writes ignored, then a legal one
        set_len(0);
        set_len(6);
        set_len(36);
        set_len(40);
        set_len(16);

        issue(VOP_FILL, 5, 0, 0, 32'h0000_FFFF, 32'd7, 0, 0, 0);        // R6 rows 20..23
        issue(VOP_SUB, 6, 5, 7, 32'hFFFF_A5A5, 0, 0, 0, 0);            // R8 bits above 16 unused

        // R3: control write in the accept cycle applies to the next instruction only
        issue(VOP_XOR, 2, 3, 4, 32'hFFFF_FFFF, 0, 1, 8, 0);
        chk(cur_len == 6'd8, "R3", "length after same-cycle write", {122'b0, cur_len}, 128'd8);
        issue(VOP_ADD, 1, 2, 3, 32'hFFFF_FFFF, 0, 0, 0, 0);

        // R9: register 11 at length 12 overlaps register 0, shifted by one row
        set_len(12);
        issue(VOP_XOR, 11, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        issue(VOP_ADD, 0, 11, 11, 32'h0000_0F3C, 0, 0, 0, 0);

        // R4 single-chunk path, R5 busy offers ignored
        set_len(4);
        issue(VOP_FILL, 31, 0, 0, 32'h0000_000B, 32'h55, 0, 0, 1);
        issue(VOP_ADD, 0, 31, 1, 32'hFFFF_FFFF, 0, 0, 0, 1);
        set_len(32);
        issue(VOP_SUB, 1, 0, 3, 32'hFFFF_FFFF, 0, 0, 0, 1);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4", "expected rows left over", 128'(q.size()), 128'd0);
        finish_run();
    end

endmodule